// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Unit

This block watches a processor's retired program counters and its data bus accesses, and raises a trigger when a configured breakpoint condition is met. It forms three terms. The PC term is a group of program-counter comparators. The address term is an inclusive address window combined with an access attribute match. The data term is a masked compare on the operand lane of the access, and it can only narrow the address term.

A mode field joins the terms. It can form a one-level condition, or a two-level sequence in which one term arms the unit and the other term fires it. The sequence can run in either order.

A small state machine holds the sequence. It has two states:

- `ST_WATCH`: waiting for a one-level hit, or for the first level of a sequence.
- `ST_ARMED`: the first level has been seen.

It has three transitions:

- `T_ARM` (`ST_WATCH` to `ST_ARMED`): a first-level hit in a two-level mode.
- `T_FIRE` (`ST_ARMED` to `ST_WATCH`): a second-level hit.
- `T_FLUSH` (either state to `ST_WATCH`): a configuration write.

A one-level hit fires from `ST_WATCH` and stays in that state.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: The PC term is true in a cycle with `pc_valid` high when any enabled comparator matches `pc_value`. Comparator i is enabled by `pc_en[i]` and compares against `pc_cmp[32*i+31:32*i]`. Comparator 0 ignores the bit positions set in `pc_mask0`. Comparators 1 to 3 match exactly.
- R2: The address term is true in a cycle with `bus_valid` high when `addr_lo <= bus_addr <= addr_hi`, bounds included, and `bus_attr` equals `attr_val` on every bit where `attr_mask` is 0.
- R3: When `data_en` is 1, the address term also needs a data match. For a byte access (`bus_size`=00), the operand is `bus_data[31:24]`, `[23:16]`, `[15:8]` or `[7:0]` for `bus_addr[1:0]` = 00, 01, 10 or 11. It is compared with `data_val[7:0]`, ignoring the bits set in `data_mask[7:0]`.
- R4: For a word access (`bus_size`=01), the operand is `bus_data[31:16]` when `bus_addr[1]` is 0 and `bus_data[15:0]` when it is 1. It is compared with the low 16 bits of `data_val` under `data_mask`. For a longword access (`bus_size` 10 or 11), all 32 bits are compared.
- R5: The one-level modes are `mode`=1 (PC), 2 (PC OR address), and 3 (address). In these modes a hit fires directly.
- R6: The two-level modes are `mode`=4 (PC, then address) and 5 (address, then PC). A first-level hit sets `armed`. The trigger fires only on a second-level hit in a later cycle, and firing clears `armed`.
- R7: `trig` is high for exactly the one cycle after the clock edge that samples a firing hit. In a two-level mode, `trig` is never high in two consecutive cycles.
- R8: `cfg_write` clears `armed` and suppresses any trigger or arming in its cycle.
- R9: `level_seen[0]` sticks at 1 when `armed` rises. `level_seen[1]` sticks at 1 when `trig` pulses. `status_clr` clears both bits, and a new event in the same cycle wins.
- R10: `mode` 0, 6 and 7 never arm and never trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Trigger mode select |
| data_en | input | 1 | Data term qualifies the address term |
| cfg_write | input | 1 | Configuration rewritten; flushes the sequence |
| status_clr | input | 1 | Clears the sticky level bits |
| pc_en | input | 4 | Per-comparator enable |
| pc_cmp | input | 128 | Four packed 32-bit PC compare values |
| pc_mask0 | input | 32 | Ignore mask for comparator 0 |
| pc_valid | input | 1 | Retired-instruction strobe |
| pc_value | input | 32 | Retired PC |
| addr_lo | input | 32 | Low bound, inclusive |
| addr_hi | input | 32 | High bound, inclusive |
| attr_val | input | 8 | Attribute compare value |
| attr_mask | input | 8 | Attribute ignore mask |
| data_val | input | 32 | Data compare value, right-aligned |
| data_mask | input | 32 | Data ignore mask, right-aligned |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | 32 | Access address |
| bus_size | input | 2 | 00 byte, 01 word, 1x longword |
| bus_attr | input | 8 | Access attributes |
| bus_data | input | 32 | Access data |
| trig | output | 1 | Trigger pulse |
| armed | output | 1 | First level seen, waiting for second |
| level_seen | output | 2 | Sticky: bit 0 armed, bit 1 fired |

## Verification
The assertions assume the following about the inputs:

- `rst_n` is low for at least one edge before activity.
- `mode` changes only in a cycle where `cfg_write` is high, so that an armed sequence never sees a mode change under it.

The bench respects this by changing the mode only together with a configuration-write cycle. Its random phases draw PCs from the comparator values and addresses near both bounds, so that hits are frequent.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int ATTR_W  = 8;
    localparam int NUM_PC  = 4;

    typedef enum logic [2:0] {
        TM_OFF        = 3'd0,
        TM_PC         = 3'd1,
        TM_PC_OR_AD   = 3'd2,
        TM_AD         = 3'd3,
        TM_PC_THEN_AD = 3'd4,
        TM_AD_THEN_PC = 3'd5
    } trig_mode_e;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_ARMED = 1'b1
    } seq_state_e;

    function automatic logic is_two_level(input logic [2:0] m);
        return (m == TM_PC_THEN_AD) || (m == TM_AD_THEN_PC);
    endfunction

    function automatic logic is_one_level(input logic [2:0] m);
        return (m == TM_PC) || (m == TM_PC_OR_AD) || (m == TM_AD);
    endfunction
endpackage

// File: rtl/bkpt_pc_term.sv
module bkpt_pc_term #(
    parameter int NCMP = 4,
    parameter int AW   = 32
) (
    input  logic                 pc_valid,
    input  logic [AW-1:0]        pc_value,
    input  logic [NCMP-1:0]      pc_en,
    input  logic [NCMP*AW-1:0]   pc_cmp,
    input  logic [AW-1:0]        pc_mask0,
    output logic                 pc_hit
);
    logic [NCMP-1:0] match;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        if (i == 0) begin : g_masked
            assign match[i] = pc_en[i] &&
                (((pc_value ^ pc_cmp[i*AW +: AW]) & ~pc_mask0) == '0);
        end else begin : g_exact
            assign match[i] = pc_en[i] && (pc_value == pc_cmp[i*AW +: AW]);
        end
    end

    assign pc_hit = pc_valid && (|match);
endmodule

// File: rtl/bkpt_addr_term.sv
module bkpt_addr_term #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int ATW = 8
) (
    input  logic           bus_valid,
    input  logic [AW-1:0]  bus_addr,
    input  logic [1:0]     bus_size,
    input  logic [ATW-1:0] bus_attr,
    input  logic [DW-1:0]  bus_data,
    input  logic [AW-1:0]  addr_lo,
    input  logic [AW-1:0]  addr_hi,
    input  logic [ATW-1:0] attr_val,
    input  logic [ATW-1:0] attr_mask,
    input  logic           data_en,
    input  logic [DW-1:0]  data_val,
    input  logic [DW-1:0]  data_mask,
    output logic           ad_hit
);
    localparam int HALF = DW / 2;
    localparam int BYTE = 8;

    logic          in_range, attr_ok, data_ok;
    logic [DW-1:0] operand, sel_mask;

    assign in_range = (bus_addr >= addr_lo) && (bus_addr <= addr_hi);
    assign attr_ok  = ((bus_attr ^ attr_val) & ~attr_mask) == '0;

    always_comb begin
        operand  = '0;
        sel_mask = '1;
        unique case (bus_size)
            2'b00: begin
                operand[BYTE-1:0]  = bus_data[(3 - bus_addr[1:0]) * BYTE +: BYTE];
                sel_mask[BYTE-1:0] = data_mask[BYTE-1:0];
            end
            2'b01: begin
                operand[HALF-1:0]  = bus_addr[1] ? bus_data[HALF-1:0]
                                                 : bus_data[DW-1:HALF];
                sel_mask[HALF-1:0] = data_mask[HALF-1:0];
            end
            default: begin
                operand  = bus_data;
                sel_mask = data_mask;
            end
        endcase
    end

    assign data_ok = ((operand ^ data_val) & ~sel_mask) == '0;
    assign ad_hit  = bus_valid && in_range && attr_ok && (!data_en || data_ok);
endmodule

// File: rtl/bkpt_seq_fsm.sv
module bkpt_seq_fsm
    import bkpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       cfg_write,
    input  logic       status_clr,
    input  logic       pc_hit,
    input  logic       ad_hit,
    output logic       trig,
    output logic       armed,
    output logic [1:0] level_seen
);
    seq_state_e state, state_nx;
    logic       one_hit, first_hit, second_hit;
    logic       fire, arm_evt;

    always_comb begin
        one_hit    = 1'b0;
        first_hit  = 1'b0;
        second_hit = 1'b0;
        unique case (mode)
            TM_PC:         one_hit = pc_hit;
            TM_PC_OR_AD:   one_hit = pc_hit || ad_hit;
            TM_AD:         one_hit = ad_hit;
            TM_PC_THEN_AD: begin first_hit = pc_hit; second_hit = ad_hit; end
            TM_AD_THEN_PC: begin first_hit = ad_hit; second_hit = pc_hit; end
            default: ;
        endcase
    end

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        arm_evt  = 1'b0;
        if (cfg_write) begin
            state_nx = ST_WATCH;
        end else begin
            unique case (state)
                ST_WATCH: begin
                    if (one_hit) begin
                        fire = 1'b1;
                    end else if (first_hit) begin
                        arm_evt  = 1'b1;
                        state_nx = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (second_hit) begin
                        fire     = 1'b1;
                        state_nx = ST_WATCH;
                    end
                end
                default: state_nx = ST_WATCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig       <= 1'b0;
            level_seen <= 2'b00;
        end else begin
            trig       <= fire;
            level_seen <= (status_clr ? 2'b00 : level_seen) | {fire, arm_evt};
        end
    end

    assign armed = (state == ST_ARMED);
endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
    import bkpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode,
    input  logic                 data_en,
    input  logic                 cfg_write,
    input  logic                 status_clr,
    input  logic [NUM_PC-1:0]    pc_en,
    input  logic [NUM_PC*ADDR_W-1:0] pc_cmp,
    input  logic [ADDR_W-1:0]    pc_mask0,
    input  logic                 pc_valid,
    input  logic [ADDR_W-1:0]    pc_value,
    input  logic [ADDR_W-1:0]    addr_lo,
    input  logic [ADDR_W-1:0]    addr_hi,
    input  logic [ATTR_W-1:0]    attr_val,
    input  logic [ATTR_W-1:0]    attr_mask,
    input  logic [DATA_W-1:0]    data_val,
    input  logic [DATA_W-1:0]    data_mask,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [ATTR_W-1:0]    bus_attr,
    input  logic [DATA_W-1:0]    bus_data,
    output logic                 trig,
    output logic                 armed,
    output logic [1:0]           level_seen
);
    logic pc_hit, ad_hit;

    bkpt_pc_term #(.NCMP(NUM_PC), .AW(ADDR_W)) u_pc (
        .pc_valid(pc_valid), .pc_value(pc_value), .pc_en(pc_en),
        .pc_cmp(pc_cmp), .pc_mask0(pc_mask0), .pc_hit(pc_hit)
    );

    bkpt_addr_term #(.AW(ADDR_W), .DW(DATA_W), .ATW(ATTR_W)) u_ad (
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_attr(bus_attr), .bus_data(bus_data), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .attr_val(attr_val), .attr_mask(attr_mask),
        .data_en(data_en), .data_val(data_val), .data_mask(data_mask),
        .ad_hit(ad_hit)
    );

    bkpt_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_write(cfg_write),
        .status_clr(status_clr), .pc_hit(pc_hit), .ad_hit(ad_hit),
        .trig(trig), .armed(armed), .level_seen(level_seen)
    );
endmodule

// File: rtl/bkpt_trigger_chk.sv
module bkpt_trigger_chk
    import bkpt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       cfg_write,
    input logic       status_clr,
    input logic       pc_valid,
    input logic       pc_hit,
    input logic       bus_valid,
    input logic       ad_hit,
    input logic       trig,
    input logic       armed,
    input logic [1:0] level_seen
);
    assert_pc_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hit |-> pc_valid);

    assert_addr_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ad_hit |-> bus_valid);

    assert_arm_only_two_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> is_two_level($past(mode)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && is_two_level($past(mode))) |=> !trig);

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write |=> (!armed && !trig));

    assert_fire_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> level_seen[1]);

    assert_clear_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (level_seen[1] == trig) && (level_seen[0] == $rose(armed)));

    assert_off_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_two_level(mode) && !is_one_level(mode)) |=> !trig);
endmodule

bind bkpt_trigger_unit bkpt_trigger_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_write(cfg_write),
    .status_clr(status_clr), .pc_valid(pc_valid), .pc_hit(pc_hit),
    .bus_valid(bus_valid), .ad_hit(ad_hit), .trig(trig), .armed(armed),
    .level_seen(level_seen)
);

// File: tb/test_bkpt_trigger_unit.sv
`timescale 1ns/1ps
module test_bkpt_trigger_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         data_en = 1'b0, cfg_write = 1'b0, status_clr = 1'b0;
    logic [3:0]   pc_en = 4'h0;
    logic [127:0] pc_cmp = '0;
    logic [31:0]  pc_mask0 = '0;
    logic         pc_valid = 1'b0;
    logic [31:0]  pc_value = '0;
    logic [31:0]  addr_lo = '0, addr_hi = '0;
    logic [7:0]   attr_val = '0, attr_mask = '0;
    logic [31:0]  data_val = '0, data_mask = '0;
    logic         bus_valid = 1'b0;
    logic [31:0]  bus_addr = '0;
    logic [1:0]   bus_size = 2'b00;
    logic [7:0]   bus_attr = '0;
    logic [31:0]  bus_data = '0;
    logic         trig, armed;
    logic [1:0]   level_seen;

    int checks = 0, errors = 0, cycles = 0;
    bit m_arm = 1'b0, m_trig = 1'b0;
    bit [1:0] m_seen = 2'b00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bkpt_trigger_unit i_bkpt_trigger_unit (.*);

    function automatic bit f_pc_hit();
        bit h = 1'b0;
        if (!pc_valid) return 1'b0;
        if (pc_en[0] && ((pc_value & ~pc_mask0) == (pc_cmp[31:0] & ~pc_mask0))) h = 1'b1;
        for (int k = 1; k < 4; k++)
            if (pc_en[k] && pc_value == pc_cmp[32*k +: 32]) h = 1'b1;
        return h;
    endfunction

    function automatic bit f_ad_hit();
        logic [31:0] op, mk, dv;
        if (!bus_valid || bus_addr < addr_lo || bus_addr > addr_hi) return 1'b0;
        if ((bus_attr & ~attr_mask) != (attr_val & ~attr_mask)) return 1'b0;
        if (!data_en) return 1'b1;
        if (bus_size == 2'b00) begin
            op = (bus_data >> (8 * (3 - bus_addr[1:0]))) & 32'hFF;
            mk = data_mask & 32'hFF; dv = data_val & 32'hFF;
        end else if (bus_size == 2'b01) begin
            op = bus_addr[1] ? {16'h0, bus_data[15:0]} : {16'h0, bus_data[31:16]};
            mk = data_mask & 32'hFFFF; dv = data_val & 32'hFFFF;
        end else begin
            op = bus_data; mk = data_mask; dv = data_val;
        end
        return (op & ~mk) == (dv & ~mk);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive inputs are already set; advance one edge while updating the model
    task automatic step(input string req);
        bit p = f_pc_hit(), a = f_ad_hit();
        bit one = 0, first = 0, second = 0, fire = 0, arm = 0;
        case (mode)
            3'd1: one = p;
            3'd2: one = p | a;
            3'd3: one = a;
            3'd4: begin first = p; second = a; end
            3'd5: begin first = a; second = p; end
            default: ;
        endcase
        if (cfg_write) m_arm = 1'b0;
        else if (!m_arm) begin
            if (one) fire = 1'b1;
            else if (first) begin arm = 1'b1; m_arm = 1'b1; end
        end else if (second) begin fire = 1'b1; m_arm = 1'b0; end
        if (status_clr) m_seen = 2'b00;
        m_seen |= {fire, arm};
        m_trig = fire;
        @(posedge clk); #1;
        check(req, "trig", trig, m_trig);
        check(req, "armed", armed, m_arm);
        check(req, "level_seen", level_seen, m_seen);
        @(negedge clk);
        cfg_write = 1'b0; status_clr = 1'b0; pc_valid = 1'b0; bus_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode = m; cfg_write = 1'b1; step("R8");
    endtask

    task automatic bus(input logic [31:0] ad, input logic [1:0] sz, input logic [31:0] d);
        bus_valid = 1'b1; bus_addr = ad; bus_size = sz; bus_data = d; bus_attr = attr_val;
    endtask

    task automatic pc(input logic [31:0] v);
        pc_valid = 1'b1; pc_value = v;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk); cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        pc_en = 4'hF;
        pc_cmp = {32'h0000_4000, 32'h0000_3000, 32'h0000_2000, 32'h0000_1000};
        pc_mask0 = 32'h0000_000F;
        addr_lo = 32'h8000_0100; addr_hi = 32'h8000_01FF;
        attr_val = 8'h5A; attr_mask = 8'h0F;
        data_val = 32'h0000_00C3; data_mask = 32'h0;
        repeat (3) @(negedge clk);
        check("R9", "reset trig", trig, 0);
        check("R9", "reset armed", armed, 0);
        check("R9", "reset seen", level_seen, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 off mode
        set_mode(3'd0); pc(32'h1000); step("R10");
        set_mode(3'd6); bus(32'h8000_0100, 2'b10, 0); step("R10");
        // R1 masked comparator 0 and exact 1..3
        set_mode(3'd1);
        pc(32'h0000_100F); step("R1");
        pc(32'h0000_101F); step("R1");
        pc(32'h0000_3000); step("R1");
        pc(32'h0000_3001); step("R1");
        // R2 inclusive bounds, attributes
        set_mode(3'd3);
        bus(32'h8000_0100, 2'b10, 0); step("R2");
        bus(32'h8000_01FF, 2'b10, 0); step("R2");
        bus(32'h8000_0200, 2'b10, 0); step("R2");
        bus(32'h8000_00FF, 2'b10, 0); step("R2");
        bus(32'h8000_0150, 2'b10, 0); bus_attr = 8'h53; step("R2");
        bus(32'h8000_0150, 2'b10, 0); bus_attr = 8'h4A; step("R2");
        // R3 byte lanes
        data_en = 1'b1;
        bus(32'h8000_0100, 2'b00, 32'hC300_0000); step("R3");
        bus(32'h8000_0101, 2'b00, 32'h00C3_0000); step("R3");
        bus(32'h8000_0102, 2'b00, 32'h0000_C300); step("R3");
        bus(32'h8000_0103, 2'b00, 32'h0000_00C3); step("R3");
        bus(32'h8000_0103, 2'b00, 32'hC300_0000); step("R3");
        // R4 word and longword lanes
        data_val = 32'h0000_BEEF;
        bus(32'h8000_0100, 2'b01, 32'hBEEF_0000); step("R4");
        bus(32'h8000_0102, 2'b01, 32'h0000_BEEF); step("R4");
        bus(32'h8000_0102, 2'b01, 32'hBEEF_0000); step("R4");
        bus(32'h8000_0104, 2'b10, 32'h0000_BEEF); step("R4");
        bus(32'h8000_0104, 2'b11, 32'h1000_BEEF); step("R4");
        data_mask = 32'hF000_0000;
        bus(32'h8000_0104, 2'b10, 32'h1000_BEEF); step("R4");
        data_mask = 0; data_en = 1'b0;
        // R5 PC or address
        set_mode(3'd2);
        pc(32'h4000); step("R5");
        bus(32'h8000_0110, 2'b10, 0); step("R5");
        // R6 two-level, same-cycle second ignored
        set_mode(3'd4);
        pc(32'h2000); bus(32'h8000_0110, 2'b10, 0); step("R6");
        bus(32'h8000_0110, 2'b10, 0); step("R6");
        step("R7");
        set_mode(3'd5);
        pc(32'h2000); step("R6");
        bus(32'h8000_0120, 2'b10, 0); step("R6");
        pc(32'h2000); step("R6");
        // R8 flush while armed
        bus(32'h8000_0120, 2'b10, 0); step("R6");
        cfg_write = 1'b1; pc(32'h2000); step("R8");
        pc(32'h2000); step("R8");
        // R9 clear, and set wins over clear
        status_clr = 1'b1; step("R9");
        bus(32'h8000_0120, 2'b10, 0); step("R9");
        status_clr = 1'b1; pc(32'h3000); step("R9");

        // random phase: mode changes only with cfg_write
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 40) == 0) begin
                mode = 3'($urandom_range(0, 7)); data_en = 1'($urandom);
                data_val = $urandom; data_mask = $urandom & $urandom;
                cfg_write = 1'b1;
            end
            status_clr = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 2) == 0)
                pc($urandom_range(0, 1) ? pc_cmp[32 * $urandom_range(0, 3) +: 32]
                                          ^ {28'h0, 4'($urandom)} : $urandom);
            if ($urandom_range(0, 2) == 0) begin
                bus(addr_lo - 2 + 32'($urandom_range(0, 260)), 2'($urandom),
                    $urandom_range(0, 1) ? $urandom : {4{data_val[7:0]}});
                if ($urandom_range(0, 3) == 0) bus_attr = 8'($urandom);
            end
            step(is_rand_req(mode));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic string is_rand_req(input logic [2:0] m);
        if (m == 3'd4 || m == 3'd5) return "R6";
        if (m >= 3'd1 && m <= 3'd3) return "R5";
        return "R10";
    endfunction
endmodule